// File: doc/BRIEF.md
# Random Bit Generator Register Controller

This block sits between a raw entropy source and a simple memory-mapped read/write port. A single noise bit arrives on `noise_in`. While the generator is switched on, the block samples that bit once every (divider+1) clocks and shifts each sample into a 64-bit accumulator. It counts samples against a target. When the target is reached, it copies the newest 64 samples into an output word and raises a ready flag. It then stops sampling until software acknowledges.

The first period after switch-on is the startup period, and its length comes from a code in the control word. Every later period is a refill period. A refill starts when software writes a 1 to the acknowledge word, and its length is the smaller of the decoded minimum and maximum refill counts, so ready never arrives later than the maximum. Software reads the low half and then the high half of the output word, and acknowledges. The interrupt line is ready gated by a mask bit.

Top module: `trng_ctrl`

## Requirements
- R1: The asynchronous active-low reset clears every register, the sample counters, the accumulator, the output word and the ready flag. After reset all reads return 0 and `irq` is 0.
- R2: Word offsets: 0x00 output bits 31:0, 0x04 output bits 63:32, 0x08 status (bit 0 = ready), 0x0C mask (bit 0), 0x10 acknowledge (reads 0), 0x14 control (bit 10 = run, bits 23:16 = startup code), 0x18 config (bits 7:0 = minimum refill code, 15:8 = divider, 23:16 = maximum refill code). The bits listed read back as written, and all other bits read 0.
- R3: In a running period, sample k is taken at the k·(divider+1)-th clock edge after the write that began the period.
- R4: Setting the run bit when it was clear begins a startup period. Its target is code·256 samples, or 2^ZERO_LOG2 samples for code 0 (2^24 by default). The status bit reads 1 exactly target·(divider+1) cycles after that write.
- R5: A refill period targets the smaller of the minimum count (code·64, or 2^ZERO_LOG2 for 0) and the maximum count (code·256, or 2^ZERO_LOG2 for 0).
- R6: When ready rises, the output word holds the last 64 samples of the period, with the most recent sample at bit 0.
- R7: While ready is 1, no samples are taken. The output word and ready stay unchanged until an acknowledge, a clear of the run bit, or a reset.
- R8: Writing acknowledge with bit 0 = 1 while running clears ready at that edge and begins a refill period, including when a period is already in progress. Writing it with bit 0 = 0 has no effect.
- R9: Clearing the run bit clears ready at that edge and stops sampling, and the output word keeps its value. Setting the run bit again begins a new startup period.
- R10: `irq` is 1 exactly when ready is 1 and mask bit 0 is 1.
- R11: Reads at unmapped or unaligned offsets return 0. Writes to the output and status words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current offset |
| addr | input | ADDR_W | Byte offset of the accessed word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| noise_in | input | 1 | Raw entropy bit |
| irq | output | 1 | Ready gated by the mask |

## Verification
The bench places the ready edge to the exact cycle for several divider values, startup codes and refill codes. A design whose divider is off by one, or whose encoding multiplier is wrong, shows ready one or more cycles early or late. It sets a minimum refill count above the maximum, so a design that ignores the maximum cap misses the edge by hundreds of cycles. It also tests the zero codes: a design that treats zero as zero samples raises ready almost at once. It checks the sample order bit by bit against the noise history it recorded, which exposes a reversed shift. It also covers an acknowledge issued in mid-period, ignored writes, and a stop while ready is held, which catch designs that keep counting or leave ready stuck high.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int unsigned FIELD_W        = 8;
  localparam int unsigned CTRL_RUN_BIT   = 10;
  localparam int unsigned CTRL_START_LSB = 16;
  localparam int unsigned CFG_MINREF_LSB = 0;
  localparam int unsigned CFG_DIV_LSB    = 8;
  localparam int unsigned CFG_MAXREF_LSB = 16;

  typedef enum logic [2:0] {
    REG_OUT_LO = 3'd0,
    REG_OUT_HI = 3'd1,
    REG_STATUS = 3'd2,
    REG_IMASK  = 3'd3,
    REG_IACK   = 3'd4,
    REG_CTRL   = 3'd5,
    REG_CFG    = 3'd6
  } reg_idx_e;
endpackage

// File: rtl/trng_sample_div.sv
module trng_sample_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && !restart && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || restart || tick) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/trng_period_ctr.sv
module trng_period_ctr #(
  parameter int unsigned CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  output logic             take,
  output logic             done,
  output logic             ready
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             ready_q, ready_d;

  assign cnt_inc = cnt_q + 1'b1;
  assign take    = run && tick && !ready_q && !clear;
  assign done    = take && (cnt_inc >= target);
  assign ready   = ready_q;

  always_comb begin
    cnt_d   = cnt_q;
    ready_d = ready_q;
    if (clear || !run) begin
      cnt_d   = '0;
      ready_d = 1'b0;
    end else if (take) begin
      cnt_d = cnt_inc;
      if (done) ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
    end
  end
endmodule

// File: rtl/trng_accum.sv
module trng_accum #(
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              done,
  input  logic              noise,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] acc_q, acc_d, word_q, word_d, shifted;

  assign shifted = {acc_q[WORD_W-2:0], noise};
  assign word    = word_q;

  always_comb begin
    acc_d  = take ? shifted : acc_q;
    word_d = done ? shifted : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      word_q <= '0;
    end else begin
      acc_q  <= acc_d;
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/trng_ctrl.sv
module trng_ctrl
  import trng_pkg::*;
#(
  parameter int unsigned ADDR_W       = 6,
  parameter int unsigned ZERO_LOG2    = 24,
  parameter int unsigned START_SHIFT  = 8,
  parameter int unsigned MINREF_SHIFT = 6,
  parameter int unsigned MAXREF_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              noise_in,
  output logic              irq
);
  localparam int unsigned SH_A   = (START_SHIFT > MINREF_SHIFT) ? START_SHIFT : MINREF_SHIFT;
  localparam int unsigned MAX_SH = (SH_A > MAXREF_SHIFT) ? SH_A : MAXREF_SHIFT;
  localparam int unsigned SPAN   = FIELD_W + MAX_SH;
  localparam int unsigned CNT_W  = ((ZERO_LOG2 > SPAN) ? ZERO_LOG2 : SPAN) + 1;
  localparam int unsigned WORD_W = 64;
  localparam logic [CNT_W-1:0] ZERO_SAMPLES = {{(CNT_W-1){1'b0}}, 1'b1} << ZERO_LOG2;

  // address decode
  logic [ADDR_W-3:0] word_idx;
  logic              mapped;
  reg_idx_e          reg_sel;
  logic              hit_ctrl, hit_cfg, hit_mask, hit_ack;

  assign word_idx = addr[ADDR_W-1:2];
  assign mapped   = (addr[1:0] == 2'b00) && (word_idx <= (ADDR_W-2)'(REG_CFG));
  assign reg_sel  = reg_idx_e'(word_idx[2:0]);
  assign hit_ctrl = wr_en && mapped && (reg_sel == REG_CTRL);
  assign hit_cfg  = wr_en && mapped && (reg_sel == REG_CFG);
  assign hit_mask = wr_en && mapped && (reg_sel == REG_IMASK);
  assign hit_ack  = wr_en && mapped && (reg_sel == REG_IACK);

  // register state
  logic               run_q, run_d;
  logic               refill_q, refill_d;
  logic               mask_q, mask_d;
  logic [FIELD_W-1:0] start_q, start_d;
  logic [FIELD_W-1:0] minref_q, minref_d;
  logic [FIELD_W-1:0] div_q, div_d;
  logic [FIELD_W-1:0] maxref_q, maxref_d;

  logic start_p, stop_p, ack_p, clear;
  assign start_p = hit_ctrl &&  wdata[CTRL_RUN_BIT] && !run_q;
  assign stop_p  = hit_ctrl && !wdata[CTRL_RUN_BIT] &&  run_q;
  assign ack_p   = hit_ack  &&  wdata[0] && run_q;
  assign clear   = start_p || stop_p || ack_p;

  logic unused_bits;
  assign unused_bits = ^{wdata[31:24], wdata[15:11], wdata[9:1]};

  always_comb begin
    run_d    = run_q;
    start_d  = start_q;
    minref_d = minref_q;
    div_d    = div_q;
    maxref_d = maxref_q;
    mask_d   = mask_q;
    refill_d = refill_q;
    if (hit_ctrl) begin
      run_d   = wdata[CTRL_RUN_BIT];
      start_d = wdata[CTRL_START_LSB +: FIELD_W];
    end
    if (hit_cfg) begin
      minref_d = wdata[CFG_MINREF_LSB +: FIELD_W];
      div_d    = wdata[CFG_DIV_LSB +: FIELD_W];
      maxref_d = wdata[CFG_MAXREF_LSB +: FIELD_W];
    end
    if (hit_mask) mask_d = wdata[0];
    if (start_p)    refill_d = 1'b0;
    else if (ack_p) refill_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      refill_q <= 1'b0;
      mask_q   <= 1'b0;
      start_q  <= '0;
      minref_q <= '0;
      div_q    <= '0;
      maxref_q <= '0;
    end else begin
      run_q    <= run_d;
      refill_q <= refill_d;
      mask_q   <= mask_d;
      start_q  <= start_d;
      minref_q <= minref_d;
      div_q    <= div_d;
      maxref_q <= maxref_d;
    end
  end

  // sample-count targets
  function automatic logic [CNT_W-1:0] decode(input logic [FIELD_W-1:0] code,
                                              input int unsigned shift);
    if (code == '0) return ZERO_SAMPLES;
    return CNT_W'(code) << shift;
  endfunction

  logic [CNT_W-1:0] start_n, minref_n, maxref_n, refill_n, target;
  assign start_n  = decode(start_q, START_SHIFT);
  assign minref_n = decode(minref_q, MINREF_SHIFT);
  assign maxref_n = decode(maxref_q, MAXREF_SHIFT);
  assign refill_n = (minref_n < maxref_n) ? minref_n : maxref_n;
  assign target   = refill_q ? refill_n : start_n;

  // datapath
  logic              tick, take, done, ready;
  logic [WORD_W-1:0] out_word;

  trng_sample_div #(.DIV_W(FIELD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run_q), .restart(clear), .div(div_q), .tick(tick)
  );

  trng_period_ctr #(.CNT_W(CNT_W)) u_period (
    .clk(clk), .rst_n(rst_n), .run(run_q), .clear(clear), .tick(tick),
    .target(target), .take(take), .done(done), .ready(ready)
  );

  trng_accum #(.WORD_W(WORD_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .take(take), .done(done), .noise(noise_in), .word(out_word)
  );

  // read port
  always_comb begin
    rdata = '0;
    if (mapped) begin
      case (reg_sel)
        REG_OUT_LO: rdata = out_word[31:0];
        REG_OUT_HI: rdata = out_word[63:32];
        REG_STATUS: rdata[0] = ready;
        REG_IMASK:  rdata[0] = mask_q;
        REG_CTRL: begin
          rdata[CTRL_RUN_BIT] = run_q;
          rdata[CTRL_START_LSB +: FIELD_W] = start_q;
        end
        REG_CFG: begin
          rdata[CFG_MINREF_LSB +: FIELD_W] = minref_q;
          rdata[CFG_DIV_LSB +: FIELD_W]    = div_q;
          rdata[CFG_MAXREF_LSB +: FIELD_W] = maxref_q;
        end
        default: rdata = '0;
      endcase
    end
  end

  assign irq = ready && mask_q;
endmodule

// File: rtl/trng_ctrl_chk.sv
module trng_ctrl_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              irq,
  input logic              run,
  input logic              ready,
  input logic [63:0]       word
);
  localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(16);

  a_r9_stopped_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !ready);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ACK_ADDR && wdata[0] && run) |=> !ready);

  a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !wr_en) |=> ready);

  a_r7_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ready) |-> $stable(word));

  a_r10_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ready);

  a_r11_unaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1:0] != 2'b00) |-> (rdata == 32'd0));
endmodule

bind trng_ctrl trng_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq(irq), .run(run_q), .ready(ready), .word(out_word)
);

// File: tb/tb_trng_ctrl.sv
module tb_trng_ctrl;
  localparam int ADDR_W = 6;
  localparam int ZLOG2  = 10;
  localparam int HIST   = 4096;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              noise = 1'b0;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit hist [HIST];
  bit finished = 1'b0;

  trng_ctrl #(.ADDR_W(ADDR_W), .ZERO_LOG2(ZLOG2)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .noise_in(noise), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    hist[cyc % HIST] <= noise;
    cyc <= cyc + 1;
  end

  always @(negedge clk) noise <= 1'($urandom);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, output int p);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1;
    p = cyc - 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_to(input int x);
    if (cyc > x) chk("timing", 64'(cyc), 64'(x));
    while (cyc < x) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_word(input int p, input int d, input int t);
    logic [63:0] w;
    for (int i = 0; i < 64; i++) w[i] = hist[(p + (t - i) * (d + 1)) % HIST];
    return w;
  endfunction

  function automatic int dec(input int code, input int mult);
    return (code == 0) ? (1 << ZLOG2) : code * mult;
  endfunction

  function automatic int refill_t(input int mn, input int mx);
    int a = dec(mn, 64);
    int b = dec(mx, 256);
    return (a < b) ? a : b;
  endfunction

  logic [63:0] last_word;

  // checks the ready edge and the captured word of one period
  task automatic period(input string tag, input int p, input int d, input int t);
    logic [31:0] s, lo, hi;
    int m = p + t * (d + 1);
    wait_to(m);
    rd(6'h08, s);
    chk({tag, " ready low before edge"}, 64'(s), 64'd0);
    wait_to(m + 1);
    rd(6'h08, s);
    chk({tag, " ready high after edge"}, 64'(s), 64'd1);
    rd(6'h00, lo);
    rd(6'h04, hi);
    last_word = exp_word(p, d, t);
    chk({tag, " R6 output word"}, {hi, lo}, last_word);
  endtask

  function automatic logic [31:0] cfgw(input int mn, input int dv, input int mx);
    return 32'((mx << 16) | (dv << 8) | mn);
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, lo, hi;
    int p, p2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(6'(a * 4), r);
      chk("R1 reset read", 64'(r), 64'd0);
    end
    chk("R1 reset irq", 64'(irq), 64'd0);

    // R2 readback
    wr(6'h18, 32'hFF_01_02_01, p);
    rd(6'h18, r);
    chk("R2 config readback", 64'(r), 64'h00_01_02_01);
    wr(6'h0C, 32'hFFFF_FFFF, p);
    rd(6'h0C, r);
    chk("R2 mask readback", 64'(r), 64'd1);
    wr(6'h10, 32'hFFFF_FFFF, p);
    rd(6'h10, r);
    chk("R2 ack reads zero", 64'(r), 64'd0);

    // R4 startup: code 1, divider 2
    wr(6'h14, 32'h0001_0400, p);
    rd(6'h14, r);
    chk("R2 control readback", 64'(r), 64'h0001_0400);
    period("R4 R3 startup div2", p, 2, 256);
    chk("R10 irq with mask", 64'(irq), 64'd1);

    // R7 hold while ready
    repeat (100) @(negedge clk);
    rd(6'h08, r);
    chk("R7 ready held", 64'(r), 64'd1);
    rd(6'h00, lo); rd(6'h04, hi);
    chk("R7 word held", {hi, lo}, last_word);

    // R11 ignored writes and unmapped reads
    wr(6'h00, 32'h1234_5678, p);
    wr(6'h04, 32'h9ABC_DEF0, p);
    wr(6'h08, 32'h0, p);
    rd(6'h08, r);
    chk("R11 status write ignored", 64'(r), 64'd1);
    rd(6'h00, lo); rd(6'h04, hi);
    chk("R11 output write ignored", {hi, lo}, last_word);
    rd(6'h1C, r); chk("R11 unmapped 0x1C", 64'(r), 64'd0);
    rd(6'h20, r); chk("R11 unmapped 0x20", 64'(r), 64'd0);
    rd(6'h3C, r); chk("R11 unmapped 0x3C", 64'(r), 64'd0);
    rd(6'h15, r); chk("R11 unaligned", 64'(r), 64'd0);

    // R8 ack with bit0 clear ignored
    wr(6'h10, 32'hFFFF_FFFE, p);
    rd(6'h08, r);
    chk("R8 ack bit0 zero ignored", 64'(r), 64'd1);

    // R10 mask off
    wr(6'h0C, 32'h0, p);
    chk("R10 irq masked", 64'(irq), 64'd0);
    wr(6'h0C, 32'h1, p);

    // R5 refill, divider 0, min 1 max 1 -> 64
    wr(6'h18, cfgw(1, 0, 1), p);
    wr(6'h10, 32'h1, p);
    rd(6'h08, r);
    chk("R8 ack clears ready", 64'(r), 64'd0);
    chk("R10 irq drops", 64'(irq), 64'd0);
    period("R5 refill min", p, 0, refill_t(1, 1));

    // R5 maximum cap: min 8 (512) max 1 (256), divider 1
    wr(6'h18, cfgw(8, 1, 1), p);
    wr(6'h10, 32'h1, p);
    period("R5 max cap", p, 1, refill_t(8, 1));

    // R5 zero code on min: min 0 (1024) max 2 (512)
    wr(6'h18, cfgw(0, 0, 2), p);
    wr(6'h10, 32'h1, p);
    period("R5 min zero capped", p, 0, refill_t(0, 2));

    // R5 zero code on max: min 20 (1280) max 0 (1024)
    wr(6'h18, cfgw(20, 0, 0), p);
    wr(6'h10, 32'h1, p);
    period("R5 max zero", p, 0, refill_t(20, 0));

    // R8 ack in mid period restarts
    wr(6'h18, cfgw(2, 1, 4), p);
    wr(6'h10, 32'h1, p);
    repeat (40) @(negedge clk);
    wr(6'h10, 32'h1, p2);
    period("R8 mid-period restart", p2, 1, refill_t(2, 4));

    // R9 stop clears ready and holds word
    wr(6'h14, 32'h0000_0000, p);
    rd(6'h08, r);
    chk("R9 stop clears ready", 64'(r), 64'd0);
    repeat (300) @(negedge clk);
    rd(6'h08, r);
    chk("R9 stopped stays low", 64'(r), 64'd0);
    rd(6'h00, lo); rd(6'h04, hi);
    chk("R9 word kept", {hi, lo}, last_word);
    wr(6'h10, 32'h1, p);
    rd(6'h08, r);
    chk("R9 ack while stopped ignored", 64'(r), 64'd0);

    // R4 zero startup code, restart after stop
    wr(6'h18, cfgw(1, 0, 1), p);
    wr(6'h14, 32'h0000_0400, p);
    period("R4 R9 zero startup code", p, 0, dec(0, 256));

    // random refills
    for (int it = 0; it < 12; it++) begin
      int mn = $urandom_range(1, 6);
      int dv = $urandom_range(0, 3);
      int mx = $urandom_range(1, 4);
      wr(6'h18, cfgw(mn, dv, mx), p);
      wr(6'h10, 32'h1, p);
      period("R3 R5 random refill", p, dv, refill_t(mn, mx));
    end

    // random startup after stop/start
    for (int it = 0; it < 4; it++) begin
      int sc = $urandom_range(1, 3);
      int dv = $urandom_range(0, 1);
      wr(6'h18, cfgw(1, dv, 1), p);
      wr(6'h14, 32'h0, p);
      wr(6'h14, 32'((sc << 16) | (1 << 10)), p);
      period("R4 random startup", p, dv, dec(sc, 256));
    end

    // R1 reset during operation
    wr(6'h10, 32'h1, p);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int a = 0; a < 7; a++) begin
      rd(6'(a * 4), r);
      chk("R1 reset mid-run", 64'(r), 64'd0);
    end
    chk("R1 reset irq mid-run", 64'(irq), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule